// File: doc/BRIEF.md
# Gamepad Input Conditioning Unit

This block sits between a decoded button source and a retro console pad port. Each clock it takes a 16-bit active-low vector of held keys and produces the active-low standard byte that the console reads as two nibbles, plus an extended byte for six-button pads and the current button mode. The standard byte and the extended byte follow the current inputs combinationally. The mode and the auto-fire phase are held in registers.

Conflicting directions are cleaned first. Up beats Down, and Left with Right gives neutral. Two three-button variants can then put the shoulder keys onto Select or Run. Holding III or IV makes the auto-fire phase pulse II or I, and L1 or R1 picks one of two pulse rates. Holding Run together with a direction is a chord that picks the button mode. The mode is taken once, on the first clock the chord is seen.

Top module: `pad_conditioner`

## Requirements
- R1: Input vector `btn_n` is active-low: bit 0 Up, 1 Right, 2 Down, 3 Left, 4 I, 5 II, 6 Select, 7 Run, 8 III, 9 IV, 10 V, 11 VI, 12 L1, 13 R1, and bits 15:14 are ignored. When Up and Down are both held, the standard byte shows Up pressed and Down released.
- R2: When Left and Right are both held, both are shown released.
- R3: `std_byte_n` is active-low, with 0 meaning pressed. Its bits are 7 Left, 6 Down, 5 Right, 4 Up, 3 Run, 2 Select, 1 II and 0 I, and they follow the cleaned inputs in the same cycle.
- R4: `mode` is encoded 0 two-button, 1 six-button, 2 three-button with Select as third, and 3 three-button with Run as third. Reset sets it to 0.
- R5: A chord is Run held together with a cleaned direction. On the clock edge where the chord first appears, `mode` becomes six-button for Up, two-button for Down, Select-as-III for Right, or Run-as-III for Left, with priority in the order Up, Down, Right, Left. Because directions are cleaned first, Run with Left and Right held together is not a chord.
- R6: A chord that stays held does not trigger again, even if its direction changes. A new mode is taken only after a cycle with no chord.
- R7: In mode 2, holding L1 or R1 forces the Select bit (bit 2) low. In modes 0 and 1, L1 and R1 leave bits 3 and 2 unchanged.
- R8: In mode 3, holding L1 or R1 forces the Run bit (bit 3) low.
- R9: In mode 1, `ext_byte_n` bits 7..4 show VI, V, IV and III active-low, and bits 3..0 read 1111. In every other mode the extended byte is 8'hFF.
- R10: The auto-fire phase starts inactive after reset and toggles after every period of the selected rate, counted in clock cycles. While the phase is active, holding III drives bit 1 (II) low and holding IV drives bit 0 (I) low.
- R11: L1 selects the fast period `FAST_CYC`. R1 selects the slow period `SLOW_CYC`, and L1 wins if both are held. With neither held, the last rate is kept, and reset selects the fast rate. Any change of rate restarts the period count at zero without toggling the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 16 | Held keys, active-low, layout as in R1 |
| std_byte_n | output | 8 | Conditioned standard byte, active-low |
| ext_byte_n | output | 8 | Extended byte for six-button mode, active-low |
| mode | output | 2 | Current button mode |

## Verification
The shoulder keys do two jobs, so two functions can act in the same cycle. In a three-button mode, holding L1 or R1 together with III forces Select or Run low, changes the auto-fire rate, and lets III inject II, all at once. The bench provokes this by holding L1 and III in Select-as-III mode and R1 and IV in Run-as-III mode across several phase toggles. A behavioural reference advances its own rate, period count and phase every clock and checks that the forced bit and the injected bit show up together, and that the injected bit alternates with the expected phase. A mode chord held during an Up+Down conflict is also judged, so that cleaning and chord priority are seen acting on the same edge.

// File: rtl/pad_pkg.sv
package pad_pkg;

   localparam int KEY_N = 14;

   localparam int K_UP    = 0;
   localparam int K_RIGHT = 1;
   localparam int K_DOWN  = 2;
   localparam int K_LEFT  = 3;
   localparam int K_I     = 4;
   localparam int K_II    = 5;
   localparam int K_SEL   = 6;
   localparam int K_RUN   = 7;
   localparam int K_III   = 8;
   localparam int K_IV    = 9;
   localparam int K_V     = 10;
   localparam int K_VI    = 11;
   localparam int K_L1    = 12;
   localparam int K_R1    = 13;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      MODE_TWO  = 2'd0,
      MODE_SIX  = 2'd1,
      MODE_SEL3 = 2'd2,
      MODE_RUN3 = 2'd3
   } pad_mode_e;

   // key index feeding each bit of the standard byte
   function automatic int std_src(input int b);
      case (b)
         0:       return K_I;
         1:       return K_II;
         2:       return K_SEL;
         3:       return K_RUN;
         4:       return K_UP;
         5:       return K_RIGHT;
         6:       return K_DOWN;
         default: return K_LEFT;
      endcase
   endfunction

   // key index feeding the upper nibble of the extended byte
   function automatic int ext_src(input int b);
      case (b)
         4:       return K_III;
         5:       return K_IV;
         6:       return K_V;
         default: return K_VI;
      endcase
   endfunction

endpackage

// File: rtl/pad_socd.sv
module pad_socd
   import pad_pkg::*;
(
   input  logic [KEY_N-1:0] press_i,
   output logic [KEY_N-1:0] press_o
);

   always_comb begin
      press_o = press_i;
      if (press_i[K_UP] && press_i[K_DOWN]) begin
         press_o[K_DOWN] = 1'b0;
      end
      if (press_i[K_LEFT] && press_i[K_RIGHT]) begin
         press_o[K_LEFT]  = 1'b0;
         press_o[K_RIGHT] = 1'b0;
      end
   end

endmodule

// File: rtl/pad_mode_latch.sv
module pad_mode_latch
   import pad_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run_i,
   input  logic      up_i,
   input  logic      down_i,
   input  logic      right_i,
   input  logic      left_i,
   output pad_mode_e mode_o
);

   logic      chord_now;
   logic      chord_seen_q;
   pad_mode_e pick;
   pad_mode_e mode_q;

   assign chord_now = run_i && (up_i || down_i || right_i || left_i);

   always_comb begin
      if (up_i)         pick = MODE_SIX;
      else if (down_i)  pick = MODE_TWO;
      else if (right_i) pick = MODE_SEL3;
      else              pick = MODE_RUN3;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q       <= MODE_TWO;
         chord_seen_q <= 1'b0;
      end else begin
         chord_seen_q <= chord_now;
         if (chord_now && !chord_seen_q) begin
            mode_q <= pick;
         end
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/pad_turbo.sv
module pad_turbo #(
   parameter int FAST_CYC = 1_666_667,
   parameter int SLOW_CYC = 4_166_667
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_req_i,
   input  logic slow_req_i,
   output logic phase_o
);

   localparam int CNT_W = $clog2(SLOW_CYC);
   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CYC - 1);

   logic             slow_q;
   logic             slow_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             phase_q;

   always_comb begin
      if (fast_req_i)      slow_nxt = 1'b0;
      else if (slow_req_i) slow_nxt = 1'b1;
      else                 slow_nxt = slow_q;
   end

   assign last = slow_q ? SLOW_LAST : FAST_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slow_q  <= 1'b0;
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (slow_nxt != slow_q) begin
         slow_q <= slow_nxt;
         cnt_q  <= '0;
      end else if (cnt_q == last) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/pad_pack.sv
module pad_pack
   import pad_pkg::*;
(
   input  logic [KEY_N-1:0]  press_i,
   input  pad_mode_e         mode_i,
   input  logic              phase_i,
   output logic [BYTE_W-1:0] std_n_o,
   output logic [BYTE_W-1:0] ext_n_o
);

   logic [BYTE_W-1:0] base;
   logic [BYTE_W-1:0] force_v;
   logic [BYTE_W-1:0] ext_base;
   logic              shoulder;

   assign shoulder = press_i[K_L1] || press_i[K_R1];

   genvar b;
   generate
      for (b = 0; b < BYTE_W; b++) begin : g_std
         assign base[b] = press_i[std_src(b)];
      end
      for (b = 0; b < BYTE_W; b++) begin : g_ext
         if (b >= 4) begin : g_hi
            assign ext_base[b] = press_i[ext_src(b)];
         end else begin : g_lo
            assign ext_base[b] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      force_v    = '0;
      force_v[0] = phase_i && press_i[K_IV];
      force_v[1] = phase_i && press_i[K_III];
      force_v[2] = (mode_i == MODE_SEL3) && shoulder;
      force_v[3] = (mode_i == MODE_RUN3) && shoulder;
   end

   assign std_n_o = ~(base | force_v);
   assign ext_n_o = (mode_i == MODE_SIX) ? ~ext_base : '1;

endmodule

// File: rtl/pad_conditioner.sv
module pad_conditioner
   import pad_pkg::*;
#(
   parameter int RAW_W    = 16,
   parameter int FAST_CYC = 1_666_667,
   parameter int SLOW_CYC = 4_166_667
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RAW_W-1:0]  btn_n,
   output logic [BYTE_W-1:0] std_byte_n,
   output logic [BYTE_W-1:0] ext_byte_n,
   output logic [1:0]        mode
);

   generate
      if (RAW_W <= KEY_N) begin : g_bad_raw
         $error("RAW_W must exceed the key count");
      end
      if (FAST_CYC < 2) begin : g_bad_fast
         $error("FAST_CYC must be at least 2");
      end
      if (SLOW_CYC <= FAST_CYC) begin : g_bad_slow
         $error("SLOW_CYC must exceed FAST_CYC");
      end
   endgenerate

   logic [KEY_N-1:0] raw_press;
   logic [KEY_N-1:0] clean_press;
   logic             unused_spare;
   pad_mode_e        mode_cur;
   logic             phase;

   assign raw_press    = ~btn_n[KEY_N-1:0];
   assign unused_spare = ^btn_n[RAW_W-1:KEY_N];

   pad_socd u_socd (
      .press_i (raw_press),
      .press_o (clean_press)
   );

   pad_mode_latch u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (clean_press[K_RUN]),
      .up_i    (clean_press[K_UP]),
      .down_i  (clean_press[K_DOWN]),
      .right_i (clean_press[K_RIGHT]),
      .left_i  (clean_press[K_LEFT]),
      .mode_o  (mode_cur)
   );

   pad_turbo #(
      .FAST_CYC (FAST_CYC),
      .SLOW_CYC (SLOW_CYC)
   ) u_turbo (
      .clk        (clk),
      .rst_n      (rst_n),
      .fast_req_i (clean_press[K_L1]),
      .slow_req_i (clean_press[K_R1]),
      .phase_o    (phase)
   );

   pad_pack u_pack (
      .press_i (clean_press),
      .mode_i  (mode_cur),
      .phase_i (phase),
      .std_n_o (std_byte_n),
      .ext_n_o (ext_byte_n)
   );

   assign mode = mode_cur;

endmodule

// File: rtl/pad_conditioner_chk.sv
module pad_conditioner_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       up_n,
   input logic       down_n,
   input logic       left_n,
   input logic       right_n,
   input logic       run_n,
   input logic       ii_n,
   input logic       iii_n,
   input logic       l1_n,
   input logic       r1_n,
   input logic [7:0] std_n,
   input logic [7:0] ext_n,
   input logic [1:0] mode
);

   assert_up_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_n && !down_n) |-> (!std_n[4] && std_n[6]));

   assert_lr_neutral_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!left_n && !right_n) |-> (std_n[7] && std_n[5]));

   // R5: mode moves only on an edge where Run was held
   assert_mode_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> !$past(run_n));

   // R6: a chord held on two consecutive edges leaves mode alone
   assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run_n) && !run_n && $past(mode) == mode && !$past(up_n) && !up_n)
      |=> (mode == $past(mode)));

   assert_sel3_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && (!l1_n || !r1_n)) |-> !std_n[2]);

   assert_run3_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && (!l1_n || !r1_n)) |-> !std_n[3]);

   assert_ext_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd1) |-> (ext_n == 8'hFF));

   assert_ii_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !std_n[1] |-> (!ii_n || !iii_n));

endmodule

bind pad_conditioner pad_conditioner_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .up_n    (btn_n[0]),
   .down_n  (btn_n[2]),
   .left_n  (btn_n[3]),
   .right_n (btn_n[1]),
   .run_n   (btn_n[7]),
   .ii_n    (btn_n[5]),
   .iii_n   (btn_n[8]),
   .l1_n    (btn_n[12]),
   .r1_n    (btn_n[13]),
   .std_n   (std_byte_n),
   .ext_n   (ext_byte_n),
   .mode    (mode)
);

// File: tb/tb_pad_conditioner.sv
`timescale 1ns/1ps
module tb_pad_conditioner;

   localparam int FAST = 5;
   localparam int SLOW = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] btn_n = 16'hFFFF;
   logic [7:0]  std_byte_n;
   logic [7:0]  ext_byte_n;
   logic [1:0]  mode;

   int checks = 0;
   int failures = 0;
   string tag = "R3";
   bit done = 0;

   // reference state
   int m_mode = 0, m_prev = 0, m_cnt = 0, m_phase = 0, m_slow = 0;

   always #10 clk = ~clk;

   pad_conditioner #(.FAST_CYC(FAST), .SLOW_CYC(SLOW)) dut (
      .clk(clk), .rst_n(rst_n), .btn_n(btn_n),
      .std_byte_n(std_byte_n), .ext_byte_n(ext_byte_n), .mode(mode));

   function automatic logic [15:0] cleaned(input logic [15:0] p);
      logic [15:0] c = p;
      if (p[0] && p[2]) c[2] = 0;
      if (p[1] && p[3]) begin c[1] = 0; c[3] = 0; end
      return c;
   endfunction

   function automatic logic [7:0] want_std(input logic [15:0] p, input int md, input int ph);
      logic [15:0] c = cleaned(p);
      logic [7:0] s;
      s = {c[3], c[2], c[1], c[0], c[7], c[6], c[5], c[4]};
      if (md == 2 && (c[12] || c[13])) s[2] = 1;
      if (md == 3 && (c[12] || c[13])) s[3] = 1;
      if (ph != 0 && c[8]) s[1] = 1;
      if (ph != 0 && c[9]) s[0] = 1;
      return ~s;
   endfunction

   function automatic logic [7:0] want_ext(input logic [15:0] p, input int md);
      if (md != 1) return 8'hFF;
      return ~{p[11], p[10], p[9], p[8], 4'b0000};
   endfunction

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // reference advance on each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_prev = 0; m_cnt = 0; m_phase = 0; m_slow = 0;
      end else begin
         logic [15:0] c;
         int chord, nslow, last;
         c = cleaned(~btn_n);
         chord = (c[7] && (c[0] || c[1] || c[2] || c[3])) ? 1 : 0;
         if (chord == 1 && m_prev == 0) begin
            if (c[0]) m_mode = 1;
            else if (c[2]) m_mode = 0;
            else if (c[1]) m_mode = 2;
            else m_mode = 3;
         end
         m_prev = chord;
         nslow = c[12] ? 0 : (c[13] ? 1 : m_slow);
         last = (m_slow != 0) ? SLOW - 1 : FAST - 1;
         if (nslow != m_slow) begin
            m_slow = nslow; m_cnt = 0;
         end else if (m_cnt == last) begin
            m_cnt = 0; m_phase = 1 - m_phase;
         end else begin
            m_cnt++;
         end
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, "std", std_byte_n, want_std(~btn_n, m_mode, m_phase));
         check("R9", "ext", ext_byte_n, want_ext(~btn_n, m_mode));
         check("R5", "mode", {6'd0, mode}, 8'(m_mode));
      end
   end

   task automatic hold(input logic [15:0] press, input int n, input string req);
      @(posedge clk); #2;
      btn_n = ~press;
      tag = req;
      repeat (n) @(posedge clk);
   endtask

   task automatic expect_mode(input int md, input string req);
      @(negedge clk);
      check(req, "mode", {6'd0, mode}, 8'(md));
   endtask

   initial begin
      #5_000_000;
      failures++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R4 reset state
      check("R4", "reset std", std_byte_n, 8'hFF);
      check("R4", "reset ext", ext_byte_n, 8'hFF);
      check("R4", "reset mode", {6'd0, mode}, 8'd0);
      rst_n = 1'b1;
      hold(16'h0000, 3, "R3");
      hold(16'h0005, 3, "R1");               // Up+Down
      @(negedge clk); check("R1", "up wins", std_byte_n, 8'hEF);
      hold(16'h000A, 3, "R2");               // Left+Right
      @(negedge clk); check("R2", "neutral", std_byte_n, 8'hFF);
      hold(16'h0009, 3, "R3");               // Up+Left
      hold(16'hC0F0, 3, "R3");               // I II Sel Run, spare bits
      @(negedge clk); check("R3", "buttons", std_byte_n, 8'hF0);
      hold(16'h0081, 2, "R5");               // Run+Up -> six
      expect_mode(1, "R5");
      hold(16'h0F00, 3, "R9");               // III..VI in six mode
      hold(16'h1000, 3, "R7");               // L1 in six: no select force
      hold(16'h0081, 2, "R6");
      hold(16'h0084, 3, "R6");               // slide to Run+Down, held
      expect_mode(1, "R6");
      hold(16'h0000, 2, "R6");
      hold(16'h0084, 2, "R5");               // Run+Down -> two
      expect_mode(0, "R5");
      hold(16'h0000, 1, "R5");
      hold(16'h008A, 3, "R5");               // Run+Left+Right: no chord
      expect_mode(0, "R5");
      hold(16'h0000, 1, "R5");
      hold(16'h0082, 2, "R7");               // Run+Right -> select-as-III
      expect_mode(2, "R7");
      hold(16'h1000, 3, "R7");
      @(negedge clk); check("R7", "sel forced", std_byte_n, 8'hFB);
      hold(16'h2000, 3, "R7");
      hold(16'h1100, 30, "R10");             // L1+III: force + turbo
      hold(16'h0000, 1, "R8");
      hold(16'h0088, 2, "R8");               // Run+Left -> run-as-III
      expect_mode(3, "R8");
      hold(16'h2000, 3, "R8");
      @(negedge clk); check("R8", "run forced", std_byte_n, 8'hF7);
      hold(16'h2200, 40, "R11");             // R1+IV slow rate
      hold(16'h0200, 30, "R11");             // rate kept
      hold(16'h1100, 7, "R11");              // back to fast mid-period
      hold(16'h0100, 30, "R10");
      hold(16'h0000, 1, "R5");
      hold(16'h0085, 2, "R5");               // Run+Up+Down -> six
      expect_mode(1, "R5");
      hold(16'h0000, 4, "R3");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule